// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control sequencer of a processor that executes each 32-bit instruction over several clock cycles, sharing a single memory and a single ALU between those cycles. It is a finite state machine. Its input is the 6-bit opcode field of the instruction register. In every state it drives one control vector to the datapath. That vector covers memory read and write, the address source, the instruction-register load, register-file write with its destination and data selects, both ALU operand selects, the ALU operation class, the PC write, the conditional PC write and the PC source.

Five instruction classes are sequenced: register-to-register arithmetic, load word, store word, branch-if-equal and jump. Every instruction starts with a common fetch step and a common decode step. Each class then takes its own short path back to fetch. A branch writes the PC only when the ALU reports a zero result. The datapath applies that condition; this block raises the qualifying enable. The operation for arithmetic instructions is settled later by a function-field decoder outside this block.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: A synchronous active-high reset puts the machine in fetch. The state is shown on `step` with these codes: fetch 0, decode 1, address-compute 2, load-read 3, load-writeback 4, store-write 5, arith-execute 6, arith-writeback 7, branch 8, jump 9.
- R2: Fetch drives `mem_rd`=1, `addr_sel`=0, `ir_ld`=1, `alu_a_sel`=0, `alu_b_sel`=01 (constant 4), `alu_op`=00 (add), `pc_we`=1 and `pc_src`=00. Fetch is always followed by decode.
- R3: Decode drives `alu_a_sel`=0, `alu_b_sel`=11 (shifted immediate) and `alu_op`=00. It then branches on `opcode`: 000000 goes to arith-execute, 100011 and 101011 go to address-compute, 000100 goes to branch, and 000010 goes to jump.
- R4: Address-compute drives `alu_a_sel`=1, `alu_b_sel`=10 (immediate) and `alu_op`=00. It then goes to load-read for opcode 100011 and to store-write for opcode 101011.
- R5: Load-read drives `mem_rd`=1 and `addr_sel`=1 and is followed by load-writeback. Load-writeback drives `rf_we`=1, `rf_dst_sel`=0 (bits 20..16) and `wb_sel`=1 (memory data).
- R6: Store-write drives `mem_wr`=1 and `addr_sel`=1.
- R7: Arith-execute drives `alu_a_sel`=1, `alu_b_sel`=00 (register B) and `alu_op`=10 (function field), and is followed by arith-writeback. Arith-writeback drives `rf_we`=1, `rf_dst_sel`=1 (bits 15..11) and `wb_sel`=0 (ALU).
- R8: Branch drives `alu_a_sel`=1, `alu_b_sel`=00, `alu_op`=01 (subtract), `pc_cond_we`=1 and `pc_src`=01 (ALU output register).
- R9: Jump drives `pc_we`=1 and `pc_src`=10 (jump target).
- R10: An opcode outside the five listed returns from decode straight to fetch, with every write enable low.
- R11: Load-writeback, store-write, arith-writeback, branch and jump all return to fetch. Every enable and select not named for a state is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the latched instruction |
| step | output | 4 | Current state code |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU output register |
| ir_ld | output | 1 | Instruction register load |
| rf_we | output | 1 | Register-file write |
| rf_dst_sel | output | 1 | Write register: 0 bits 20..16, 1 bits 15..11 |
| wb_sel | output | 1 | Write data: 0 ALU, 1 memory data |
| alu_a_sel | output | 1 | ALU A: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B: 00 reg B, 01 four, 10 imm, 11 shifted imm |
| alu_op | output | 2 | 00 add, 01 subtract, 10 function field |
| pc_we | output | 1 | Unconditional PC write |
| pc_cond_we | output | 1 | PC write qualified by ALU zero |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALU output reg, 10 jump target |

## Verification
One instruction of each class is run through a full fetch-to-fetch pass, so the five paths out of decode, and the load/store split after address compute, are each exercised. Load and store share the address step; running both back to back shows whether the second opcode check separates them. An unused opcode shows that decode falls straight back to fetch with no writes. A reset raised in the middle of an arithmetic instruction shows that the restart is synchronous and does not depend on the state.

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm (
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  output logic [3:0] step,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       addr_sel,
  output logic       ir_ld,
  output logic       rf_we,
  output logic       rf_dst_sel,
  output logic       wb_sel,
  output logic       alu_a_sel,
  output logic [1:0] alu_b_sel,
  output logic [1:0] alu_op,
  output logic       pc_we,
  output logic       pc_cond_we,
  output logic [1:0] pc_src
);
  localparam logic [5:0] OP_ARITH = 6'b000000;
  localparam logic [5:0] OP_LOAD  = 6'b100011;
  localparam logic [5:0] OP_STORE = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_JMP   = 6'b000010;

  typedef enum logic [3:0] {
    S_FETCH = 4'd0, S_DECODE = 4'd1, S_ADDR = 4'd2, S_LDRD = 4'd3,
    S_LDWB  = 4'd4, S_STWR   = 4'd5, S_AEXE = 4'd6, S_AWB  = 4'd7,
    S_BR    = 4'd8, S_JMP    = 4'd9
  } state_t;

  state_t cur, nxt;

  always_ff @(posedge clk)
    if (rst) cur <= S_FETCH;
    else     cur <= nxt;

  assign step = cur;

  always_comb begin
    nxt = S_FETCH;
    unique case (cur)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: case (opcode)
                  OP_ARITH:          nxt = S_AEXE;
                  OP_LOAD, OP_STORE: nxt = S_ADDR;
                  OP_BEQ:            nxt = S_BR;
                  OP_JMP:            nxt = S_JMP;
                  default:           nxt = S_FETCH;
                endcase
      S_ADDR:   nxt = (opcode == OP_LOAD)  ? S_LDRD :
                      (opcode == OP_STORE) ? S_STWR : S_FETCH;
      S_LDRD:   nxt = S_LDWB;
      S_AEXE:   nxt = S_AWB;
      default:  nxt = S_FETCH;
    endcase
  end

  always_comb begin
    mem_rd = 1'b0; mem_wr = 1'b0; addr_sel = 1'b0; ir_ld = 1'b0;
    rf_we = 1'b0; rf_dst_sel = 1'b0; wb_sel = 1'b0; alu_a_sel = 1'b0;
    alu_b_sel = 2'b00; alu_op = 2'b00; pc_we = 1'b0; pc_cond_we = 1'b0;
    pc_src = 2'b00;
    unique case (cur)
      S_FETCH: begin
        mem_rd = 1'b1; ir_ld = 1'b1; alu_b_sel = 2'b01; pc_we = 1'b1;
      end
      S_DECODE: alu_b_sel = 2'b11;
      S_ADDR: begin
        alu_a_sel = 1'b1; alu_b_sel = 2'b10;
      end
      S_LDRD: begin
        mem_rd = 1'b1; addr_sel = 1'b1;
      end
      S_LDWB: begin
        rf_we = 1'b1; wb_sel = 1'b1;
      end
      S_STWR: begin
        mem_wr = 1'b1; addr_sel = 1'b1;
      end
      S_AEXE: begin
        alu_a_sel = 1'b1; alu_op = 2'b10;
      end
      S_AWB: begin
        rf_we = 1'b1; rf_dst_sel = 1'b1;
      end
      S_BR: begin
        alu_a_sel = 1'b1; alu_op = 2'b01; pc_cond_we = 1'b1; pc_src = 2'b01;
      end
      S_JMP: begin
        pc_we = 1'b1; pc_src = 2'b10;
      end
      default: ;
    endcase
  end
endmodule

module mc_ctrl_fsm_chk (
  input logic       clk,
  input logic       rst,
  input logic [5:0] opcode,
  input logic [3:0] step,
  input logic       mem_wr,
  input logic       addr_sel,
  input logic       ir_ld,
  input logic       rf_we,
  input logic [1:0] alu_b_sel,
  input logic [1:0] alu_op,
  input logic       pc_we,
  input logic       pc_cond_we
);
  p_reset_fetch_r1: assert property (@(posedge clk) rst |=> step == 4'd0);
  p_fetch_then_decode_r2: assert property (@(posedge clk) disable iff (rst)
    step == 4'd0 |=> step == 4'd1);
  p_fetch_ld_r2: assert property (@(posedge clk) disable iff (rst)
    ir_ld |-> pc_we && alu_b_sel == 2'b01);
  p_cond_sub_r8: assert property (@(posedge clk) disable iff (rst)
    pc_cond_we |-> alu_op == 2'b01 && alu_b_sel == 2'b00 && !pc_we);
  p_store_addr_r6: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> addr_sel);
  p_unused_op_r10: assert property (@(posedge clk) disable iff (rst)
    (step == 4'd1 && !(opcode inside {6'b000000, 6'b100011, 6'b101011, 6'b000100, 6'b000010}))
    |=> step == 4'd0 && !rf_we && !mem_wr && !pc_cond_we);
  p_one_write_r11: assert property (@(posedge clk) disable iff (rst)
    $countones({mem_wr, rf_we, pc_cond_we}) <= 1);
endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk u_chk (
  .clk(clk), .rst(rst), .opcode(opcode), .step(step), .mem_wr(mem_wr),
  .addr_sel(addr_sel), .ir_ld(ir_ld), .rf_we(rf_we), .alu_b_sel(alu_b_sel),
  .alu_op(alu_op), .pc_we(pc_we), .pc_cond_we(pc_cond_we)
);

// File: tb/mc_ctrl_fsm_test.sv
module mc_ctrl_fsm_test;
  logic clk = 1'b0, rst = 1'b1;
  logic [5:0] opcode = 6'b111111;
  logic [3:0] step;
  logic mem_rd, mem_wr, addr_sel, ir_ld, rf_we, rf_dst_sel, wb_sel, alu_a_sel;
  logic [1:0] alu_b_sel, alu_op, pc_src;
  logic pc_we, pc_cond_we;
  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  typedef struct packed { logic [19:0] vec; logic [7:0] tag; } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  mc_ctrl_fsm uut (
    .clk(clk), .rst(rst), .opcode(opcode), .step(step), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .addr_sel(addr_sel), .ir_ld(ir_ld), .rf_we(rf_we),
    .rf_dst_sel(rf_dst_sel), .wb_sel(wb_sel), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .alu_op(alu_op), .pc_we(pc_we),
    .pc_cond_we(pc_cond_we), .pc_src(pc_src)
  );

  // vector: step, mem_rd, mem_wr, addr_sel, ir_ld, rf_we, rf_dst_sel, wb_sel,
  // alu_a_sel, alu_b_sel, alu_op, pc_we, pc_cond_we, pc_src
  function automatic logic [19:0] expect_for(input logic [3:0] s);
    case (s)
      4'd0: return {s, 8'b1001_0000, 2'b01, 2'b00, 2'b10, 2'b00}; // R2
      4'd1: return {s, 8'b0000_0000, 2'b11, 2'b00, 2'b00, 2'b00}; // R3
      4'd2: return {s, 8'b0000_0001, 2'b10, 2'b00, 2'b00, 2'b00}; // R4
      4'd3: return {s, 8'b1010_0000, 2'b00, 2'b00, 2'b00, 2'b00}; // R5
      4'd4: return {s, 8'b0000_1010, 2'b00, 2'b00, 2'b00, 2'b00}; // R5
      4'd5: return {s, 8'b0110_0000, 2'b00, 2'b00, 2'b00, 2'b00}; // R6
      4'd6: return {s, 8'b0000_0001, 2'b00, 2'b10, 2'b00, 2'b00}; // R7
      4'd7: return {s, 8'b0000_1100, 2'b00, 2'b00, 2'b00, 2'b00}; // R7
      4'd8: return {s, 8'b0000_0001, 2'b00, 2'b01, 2'b01, 2'b01}; // R8
      default: return {s, 8'b0000_0000, 2'b00, 2'b00, 2'b10, 2'b10}; // R9
    endcase
  endfunction

  task automatic push(input logic [3:0] s, input logic [7:0] tag);
    item_t it;
    it.vec = expect_for(s);
    it.tag = tag;
    q.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic run_instr(input logic [5:0] op, input logic [7:0] tag,
                           input logic [3:0] s2, input logic [3:0] s3,
                           input logic [3:0] s4, input int n);
    opcode = op;
    push(4'd0, 8'd2);
    push(4'd1, 8'd3);
    if (n > 0) push(s2, tag);
    if (n > 1) push(s3, tag);
    if (n > 2) push(s4, tag);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [19:0] act;
      it = q.pop_front();
      act = {step, mem_rd, mem_wr, addr_sel, ir_ld, rf_we, rf_dst_sel, wb_sel,
             alu_a_sel, alu_b_sel, alu_op, pc_we, pc_cond_we, pc_src};
      compared++;
      if (act !== it.vec) begin
        mismatched++;
        $display("FAIL R%0d: actual %b expected %b", it.tag, act, it.vec);
      end
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    // R1: reset lands in fetch
    run_instr(6'b000000, 8'd7, 4'd6, 4'd7, 4'd0, 2);   // R7 arith
    run_instr(6'b100011, 8'd5, 4'd2, 4'd3, 4'd4, 3);   // R4 R5 load
    run_instr(6'b101011, 8'd6, 4'd2, 4'd5, 4'd0, 2);   // R4 R6 store
    run_instr(6'b000100, 8'd8, 4'd8, 4'd0, 4'd0, 1);   // R8 branch
    run_instr(6'b000010, 8'd9, 4'd9, 4'd0, 4'd0, 1);   // R9 jump
    run_instr(6'b111111, 8'd10, 4'd0, 4'd0, 4'd0, 0);  // R10 unused
    run_instr(6'b000001, 8'd10, 4'd0, 4'd0, 4'd0, 0);  // R10 unused
    // R11: returns to fetch after each last state (checked by next fetch)
    run_instr(6'b000000, 8'd7, 4'd6, 4'd0, 4'd0, 1);
    rst = 1'b1;                                         // R1 mid-instruction reset
    push(4'd7, 8'd1);
    rst = 1'b0;
    push(4'd0, 8'd1);
    push(4'd1, 8'd11);
    @(negedge clk); @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 2000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL R1: watchdog actual hung expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule